// File: doc/BRIEF.md
# Buffered Block Program Engine

This engine carries out the multi-word program sequence of a parallel flash array. The command sequencer issues a start strobe. The next write gives a word count. Data writes follow, and a final write holds the confirm byte. None of the data goes into the array directly.

On the first data word the engine loads a shadow buffer with the current contents of the aligned write block. It then writes each accepted word into that buffer and checks that every address falls inside the block. The array is updated in one step, and only when the confirm byte is 0xD0 and no program error is pending. Any other ending throws the buffer away, and the array keeps its old contents.

Copies between the array and the buffer move one word per clock. During a copy the engine raises `busy`, and the sequencer stalls while `busy` is high. Two sticky status bits give the result:
- `prog_err` flags a rejected write.
- `ready` shows that a data write or a commit has taken place.

Top module: `flash_buf_prog`

## Requirements
- R1: After reset the engine is idle, `busy`, `ready` and `prog_err` are 0, and every storage word reads all ones.
- R2: The first write after `start` is the count. Only its low DEV_W bits are kept. A count of N makes the engine accept N+1 data writes, and the write after those is taken as the confirm byte.
- R3: A data write that arrives with the count nonzero and no buffer open opens a buffer. The buffer base is the write address with its low BLK_LOG2 bits cleared. The engine copies the 2^BLK_LOG2 words of that block into the buffer, holding `busy` high for exactly 2^BLK_LOG2 cycles, and then applies the write that triggered the copy.
- R4: A data write whose address lies outside the open block sets `prog_err`, and the data is dropped.
- R5: A data write while `ro` is high sets `prog_err` and its data is not stored. A data write while no buffer is open also sets `prog_err` and is not stored; this includes the first write of a zero count.
- R6: Every data write sets `ready`.
- R7: At the confirm stage, the byte 0xD0 (bits 7:0 of `wr_data`) with `prog_err` clear copies the buffer to storage. `busy` stays high for 2^BLK_LOG2 cycles, the buffer then closes, `ready` is set and the engine returns to idle.
- R8: Any other confirm byte, or 0xD0 while `prog_err` is set, discards the buffer and returns the engine to idle with storage unchanged.
- R9: `stat_clr` clears `prog_err` and `ready`.
- R10: Storage contents change only during a commit copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ro | input | 1 | Array is read-only |
| start | input | 1 | Buffered program command issued |
| wr_en | input | 1 | Write strobe (count, data or confirm, depending on stage) |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | BANK_W | Write data |
| stat_clr | input | 1 | Clear status bits |
| rd_addr | input | ADDR_W | Storage read address |
| rd_data | output | BANK_W | Storage word at rd_addr |
| busy | output | 1 | Copy in progress, sequencer must stall |
| ready | output | 1 | Sticky ready status bit |
| prog_err | output | 1 | Sticky program error status bit |

## Verification
The bench builds the engine with its defaults:
- a 16-bit bank word;
- an 8-bit device width;
- a 64-word array;
- 8-word write blocks.

The device width is narrower than the word, so a count written with a nonzero high byte shows whether masking takes place. The small blocks keep each copy short enough to count busy cycles exactly. They also allow several independent blocks to be used in one run, so a final sweep of the array can confirm that rejected and aborted sequences left their blocks untouched.

// File: rtl/flash_buf_prog.sv
module flash_buf_prog #(
  parameter int ADDR_W   = 6,
  parameter int BANK_W   = 16,
  parameter int DEV_W    = 8,
  parameter int BLK_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ro,
  input  logic              start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_data,
  input  logic              stat_clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BANK_W-1:0] rd_data,
  output logic              busy,
  output logic              ready,
  output logic              prog_err
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int BLK    = 1 << BLK_LOG2;
  localparam int BASE_W = ADDR_W - BLK_LOG2;
  localparam logic [7:0] CONFIRM = 8'hD0;

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_DATA, S_CONF, S_IN, S_OUT} stage_t;

  stage_t              st;
  logic [BANK_W-1:0]   mem  [WORDS];
  logic [BANK_W-1:0]   wbuf [BLK];
  logic [BANK_W-1:0]   cnt;
  logic [BASE_W-1:0]   base;
  logic [BLK_LOG2-1:0] idx;
  logic [BLK_LOG2-1:0] p_off;
  logic [BANK_W-1:0]   p_data;
  logic                open;

  wire                at_base = wr_addr[ADDR_W-1:BLK_LOG2] == base;
  wire [BLK_LOG2-1:0] w_off   = wr_addr[BLK_LOG2-1:0];
  wire [ADDR_W-1:0]   cp_addr = {base, idx};

  assign rd_data  = mem[rd_addr];
  assign busy     = (st == S_IN) || (st == S_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      open     <= 1'b0;
      prog_err <= 1'b0;
      ready    <= 1'b0;
      cnt      <= '0;
      base     <= '0;
      idx      <= '0;
      p_off    <= '0;
      p_data   <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (stat_clr) begin
        prog_err <= 1'b0;
        ready    <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) st <= S_CNT;
        S_CNT: if (wr_en) begin
          cnt <= BANK_W'(wr_data[DEV_W-1:0]);
          st  <= S_DATA;
        end
        S_DATA: if (wr_en) begin
          ready <= 1'b1;
          if (!open && cnt != '0) begin
            base   <= wr_addr[ADDR_W-1:BLK_LOG2];
            p_off  <= w_off;
            p_data <= wr_data;
            idx    <= '0;
            st     <= S_IN;
          end else begin
            if (ro || !open || !at_base) prog_err <= 1'b1;
            else wbuf[w_off] <= wr_data;
            cnt <= cnt - 1'b1;
            if (cnt == '0) st <= S_CONF;
          end
        end
        S_IN: begin
          wbuf[idx] <= mem[cp_addr];
          idx       <= idx + 1'b1;
          if (idx == BLK_LOG2'(BLK - 1)) begin
            open <= 1'b1;
            if (ro) prog_err <= 1'b1;
            else wbuf[p_off] <= p_data;
            cnt <= cnt - 1'b1;
            st  <= S_DATA;
          end
        end
        S_CONF: if (wr_en) begin
          if (wr_data[7:0] == CONFIRM && !prog_err && open) begin
            idx <= '0;
            st  <= S_OUT;
          end else begin
            open <= 1'b0;
            st   <= S_IDLE;
          end
        end
        S_OUT: begin
          mem[cp_addr] <= wbuf[idx];
          idx          <= idx + 1'b1;
          if (idx == BLK_LOG2'(BLK - 1)) begin
            open  <= 1'b0;
            ready <= 1'b1;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  open_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && wr_en && !open && cnt != '0) |=> busy);

  // R4
  out_of_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && wr_en && open && !at_base) |=> prog_err);

  // R5
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && wr_en && ro && (open || cnt == '0)) |=> prog_err);

  // R6
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && wr_en) |=> ready);

  // R7
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONF && wr_en && wr_data[7:0] == CONFIRM && !prog_err && open) |=> busy);

  // R8
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONF && wr_en && (wr_data[7:0] != CONFIRM || prog_err)) |=> (!busy && !open));

  // R10
  storage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_OUT) ##1 $stable(rd_addr) |-> $stable(rd_data));
endmodule

// File: tb/test_flash_buf_prog.sv
`timescale 1ns/1ps
module test_flash_buf_prog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ro = 1'b0, start = 1'b0, wr_en = 1'b0, stat_clr = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        busy, ready, prog_err;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [64];

  always #2.5 clk = ~clk;

  flash_buf_prog i_flash_buf_prog (
    .clk(clk), .rst_n(rst_n), .ro(ro), .start(start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .stat_clr(stat_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .ready(ready),
    .prog_err(prog_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, output int n);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic clr();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic peek(input string req, input logic [5:0] a);
    @(negedge clk); rd_addr = a; #0.1;
    chk(req, rd_data, model[a]);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 ready", ready, 0);
    chk("R1 prog_err", prog_err, 0);
    for (int i = 0; i < 64; i++) peek("R1 storage", 6'(i));
  endtask

  task automatic t_commit();
    int n;
    do_start();
    wr(6'd0, 16'h0002, n);
    wr(6'd10, 16'hA010, n);
    chk("R3 copy-in busy cycles", n, 8);
    chk("R6 ready after data", ready, 1);
    wr(6'd11, 16'hA011, n);
    wr(6'd12, 16'hA012, n);
    chk("R3 no second copy", n, 0);
    wr(6'd0, 16'h00D0, n);
    chk("R7 commit busy cycles", n, 8);
    chk("R7 ready", ready, 1);
    chk("R7 no error", prog_err, 0);
    model[10] = 16'hA010; model[11] = 16'hA011; model[12] = 16'hA012;
    for (int i = 8; i < 16; i++) peek("R7 block contents", 6'(i));
  endtask

  task automatic t_mask();
    int n;
    do_start();
    wr(6'd0, 16'hAB01, n);
    wr(6'd33, 16'hB033, n);
    wr(6'd34, 16'hB034, n);
    wr(6'd0, 16'h00D0, n);
    chk("R2 confirm after count+1 words", n, 8);
    model[33] = 16'hB033; model[34] = 16'hB034;
    peek("R2 word 33", 6'd33);
    peek("R2 word 34", 6'd34);
  endtask

  task automatic t_oob();
    int n;
    clr();
    do_start();
    wr(6'd0, 16'h0001, n);
    wr(6'd17, 16'h1111, n);
    chk("R4 in-block no error", prog_err, 0);
    wr(6'd30, 16'h2222, n);
    chk("R4 out-of-block error", prog_err, 1);
    wr(6'd0, 16'h00D0, n);
    chk("R8 confirm rejected on error", n, 0);
    peek("R8 word 17 untouched", 6'd17);
    peek("R4 word 30 untouched", 6'd30);
    clr();
    chk("R9 error cleared", prog_err, 0);
    chk("R9 ready cleared", ready, 0);
  endtask

  task automatic t_abort();
    int n;
    do_start();
    wr(6'd0, 16'h0001, n);
    wr(6'd40, 16'hC040, n);
    wr(6'd41, 16'hC041, n);
    wr(6'd0, 16'h00FF, n);
    chk("R8 abort no copy", n, 0);
    peek("R8 word 40 untouched", 6'd40);
    do_start();
    wr(6'd0, 16'h0001, n);
    wr(6'd40, 16'hD040, n);
    wr(6'd41, 16'hD041, n);
    wr(6'd0, 16'h00D0, n);
    chk("R8 idle after abort, next commit", n, 8);
    model[40] = 16'hD040; model[41] = 16'hD041;
    peek("R8 word 40 new", 6'd40);
    peek("R8 word 41 new", 6'd41);
  endtask

  task automatic t_ro();
    int n;
    clr();
    ro = 1'b1;
    do_start();
    wr(6'd0, 16'h0001, n);
    wr(6'd48, 16'hE048, n);
    chk("R5 read-only error", prog_err, 1);
    wr(6'd49, 16'hE049, n);
    wr(6'd0, 16'h00D0, n);
    chk("R5 read-only commit refused", n, 0);
    ro = 1'b0;
    peek("R5 word 48 untouched", 6'd48);
    clr();
  endtask

  task automatic t_zero();
    int n;
    do_start();
    wr(6'd0, 16'h0000, n);
    wr(6'd56, 16'h5555, n);
    chk("R5 zero count no copy", n, 0);
    chk("R5 no buffer error", prog_err, 1);
    chk("R6 ready on rejected write", ready, 1);
    wr(6'd0, 16'h00D0, n);
    chk("R8 zero count confirm refused", n, 0);
    peek("R5 word 56 untouched", 6'd56);
    clr();
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 64; i++) peek("R10 final storage", 6'(i));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_mask();
    t_oob();
    t_abort();
    t_ro();
    t_zero();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule